// File: doc/BRIEF.md
# Rotate and Shift Unit with Carry

This execution unit shifts or rotates an operand by a 5-bit count. It supports logical left and right shifts, arithmetic right shift, plain left and right rotates, and left and right rotates through the carry flag. It also returns the new carry flag. Operands may be 8, 16 or 32 bits wide. Every result is confined to the active width.

In a rotate through carry, the incoming carry acts as one extra bit attached to the operand. For a left rotate that bit sits above the operand, and for a right rotate it sits below. After every operation the carry flag holds the last bit that left the operand. The upstream decoder chooses between an immediate count and a register count before the value reaches this unit.

The unit registers its result and carry once, so a request presented on one clock edge shows its outcome after that edge. The carry flag that the surrounding pipeline holds is fed back into `cf_i` for the next operation.

Top module: `rot_shift_unit`

## Requirements
- R1: Results and carry are registered, so the outcome of the inputs sampled at a rising clock edge is visible after that edge. An asynchronous active-low reset clears `res_o` to 0 and `cf_o` to 0.
- R2: When the count is zero, the result equals the operand confined to the active width, and the carry equals `cf_i`. This holds for every operation code.
- R3: A logical left or right shift fills vacated positions with zeros. The carry is the last bit moved out. A count equal to the width gives a zero result, with the carry equal to the end bit moved out last. A count above the width gives a zero result and a zero carry.
- R4: An arithmetic right shift fills vacated positions with the operand's sign bit, which is bit width-1. The carry is the last bit moved out. A count at or above the width gives all sign bits, with the carry equal to the sign.
- R5: A plain rotate reinserts the bits moved out of one end at the other end, using the count modulo the width. After a left rotate the carry equals result bit 0. After a right rotate it equals result bit width-1. This also holds when the reduced count is zero but the count is not.
- R6: A rotate through carry rotates the (width+1)-bit value formed from the operand and the carry, using the count modulo width+1. For a left rotate the carry is the extra top bit, and for a right rotate it is the extra bottom bit. The new carry is the extension bit after the rotate. A reduced count of zero leaves both the result and the carry unchanged.
- R7: `wsel_i` selects the width: 00 selects 8 bits, 01 selects 16 bits, and 10 or 11 select 32 bits. Operand bits above the active width are ignored, and result bits above it are 0.
- R8: The `op_i` codes are: 0 shift left, 1 logical shift right, 2 arithmetic shift right, 3 rotate left, 4 rotate right, 5 rotate left through carry, 6 rotate right through carry. Code 7 passes the confined operand through and keeps the carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| opnd_i | input | 32 | Operand |
| cnt_i | input | 5 | Shift or rotate count |
| op_i | input | 3 | Operation code |
| wsel_i | input | 2 | Operand width select |
| cf_i | input | 1 | Current carry flag |
| res_o | output | 32 | Registered result |
| cf_o | output | 1 | Registered new carry flag |

## Verification
The assertions compare each output with the inputs of the cycle before. They are therefore only valid once one full clock edge has passed out of reset. A local arming flag holds them off until then. They also assume that the inputs are stable around the rising edge. The bench meets this by changing every input only on the falling edge, and it feeds the counts, widths and operation codes across their full encoded ranges, including the spare code and both encodings for 32 bits.

// File: rtl/rot_shift_unit.sv
module rot_shift_unit (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] opnd_i,
  input  logic [4:0]  cnt_i,
  input  logic [2:0]  op_i,
  input  logic [1:0]  wsel_i,
  input  logic        cf_i,
  output logic [31:0] res_o,
  output logic        cf_o
);
  localparam logic [2:0] OP_SHL = 3'd0;
  localparam logic [2:0] OP_SHR = 3'd1;
  localparam logic [2:0] OP_SAR = 3'd2;
  localparam logic [2:0] OP_ROL = 3'd3;
  localparam logic [2:0] OP_ROR = 3'd4;
  localparam logic [2:0] OP_RCL = 3'd5;
  localparam logic [2:0] OP_RCR = 3'd6;

  logic [5:0]  w;
  logic [31:0] mask, a, sx;
  logic [4:0]  kr, kc;

  always_comb begin
    case (wsel_i)
      2'b00:   w = 6'd8;
      2'b01:   w = 6'd16;
      default: w = 6'd32;
    endcase
  end

  assign mask = (w == 6'd32) ? '1 : ((32'd1 << w) - 32'd1);
  assign a    = opnd_i & mask;
  assign sx   = a | (a[w - 6'd1] ? ~mask : 32'd0);
  assign kr   = cnt_i & 5'(w - 6'd1);

  always_comb begin
    case (wsel_i)
      2'b00:   kc = cnt_i % 5'd9;
      2'b01:   kc = cnt_i % 5'd17;
      default: kc = cnt_i;
    endcase
  end

  logic [32:0] t, c, mk33, rc;
  logic [31:0] r;
  logic        co;

  assign c    = {1'b0, a} | (33'(cf_i) << w);
  assign mk33 = {1'b0, mask} | (33'd1 << w);

  always_comb begin
    t  = '0;
    rc = '0;
    r  = a;
    co = cf_i;
    case (op_i)
      OP_SHL: begin
        t  = {1'b0, a} << cnt_i;
        r  = t[31:0];
        co = t[w];
      end
      OP_SHR: begin
        t  = {a, 1'b0} >> cnt_i;
        r  = t[32:1];
        co = t[0];
      end
      OP_SAR: begin
        t  = 33'($signed({sx, 1'b0}) >>> cnt_i);
        r  = t[32:1];
        co = t[0];
      end
      OP_ROL: begin
        r  = ((a << kr) | (a >> (w - 6'(kr)))) & mask;
        co = r[0];
      end
      OP_ROR: begin
        r  = ((a >> kr) | (a << (w - 6'(kr)))) & mask;
        co = r[w - 6'd1];
      end
      OP_RCL: begin
        rc = ((c << kc) | (c >> (w + 6'd1 - 6'(kc)))) & mk33;
        r  = rc[31:0];
        co = rc[w];
      end
      OP_RCR: begin
        rc = ((c >> kc) | (c << (w + 6'd1 - 6'(kc)))) & mk33;
        r  = rc[31:0];
        co = rc[w];
      end
      default: begin
        r  = a;
        co = cf_i;
      end
    endcase
    if (cnt_i == 5'd0) begin
      r  = a;
      co = cf_i;
    end
    r = r & mask;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_o <= '0;
      cf_o  <= 1'b0;
    end else begin
      res_o <= r;
      cf_o  <= co;
    end
  end
endmodule

// File: rtl/rot_shift_unit_chk.sv
module rot_shift_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [31:0] opnd_i,
  input logic [4:0]  cnt_i,
  input logic [2:0]  op_i,
  input logic [1:0]  wsel_i,
  input logic        cf_i,
  input logic [31:0] res_o,
  input logic        cf_o
);
  logic [5:0]  wb;
  logic [4:0]  top;
  logic [31:0] msk;
  logic        armed;

  assign wb  = (wsel_i == 2'b00) ? 6'd8 : (wsel_i == 2'b01) ? 6'd16 : 6'd32;
  assign top = 5'(wb - 6'd1);
  assign msk = (wb == 6'd32) ? '1 : ((32'd1 << wb) - 32'd1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  AST_ZERO_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    armed && $past(cnt_i) == 5'd0 |-> res_o == $past(opnd_i & msk) && cf_o == $past(cf_i)); // R2
  AST_UPPER_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> (res_o & ~$past(msk)) == 32'd0); // R7
  AST_ROL_CARRY_LSB: assert property (@(posedge clk) disable iff (!rst_n)
    armed && $past(op_i) == 3'd3 && $past(cnt_i) != 5'd0 |-> cf_o == res_o[0]); // R5
  AST_ROR_CARRY_MSB: assert property (@(posedge clk) disable iff (!rst_n)
    armed && $past(op_i) == 3'd4 && $past(cnt_i) != 5'd0 |-> cf_o == res_o[$past(top)]); // R5
  AST_SHL_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    armed && $past(op_i) == 3'd0 && 6'($past(cnt_i)) >= $past(wb) |-> res_o == 32'd0); // R3
  AST_SAR_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    armed && $past(op_i) == 3'd2 && 6'($past(cnt_i)) >= $past(wb)
    |-> cf_o == $past(opnd_i[top]) && res_o == ($past(opnd_i[top]) ? $past(msk) : 32'd0)); // R4
  AST_SPARE_OP_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    armed && $past(op_i) == 3'd7 |-> res_o == $past(opnd_i & msk) && cf_o == $past(cf_i)); // R8
endmodule

bind rot_shift_unit rot_shift_unit_chk chk_i (
  .clk(clk), .rst_n(rst_n), .opnd_i(opnd_i), .cnt_i(cnt_i), .op_i(op_i),
  .wsel_i(wsel_i), .cf_i(cf_i), .res_o(res_o), .cf_o(cf_o)
);

// File: tb/rot_shift_unit_tb_top.sv
module rot_shift_unit_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] opnd_i = '0;
  logic [4:0]  cnt_i = '0;
  logic [2:0]  op_i = '0;
  logic [1:0]  wsel_i = '0;
  logic        cf_i = 1'b0;
  logic [31:0] res_o;
  logic        cf_o;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [31:0] exp_res_q[$];
  logic        exp_cf_q[$];
  string       tag_q[$];

  always #(CLK_PERIOD / 2) clk = ~clk;

  rot_shift_unit dut_i (.clk(clk), .rst_n(rst_n), .opnd_i(opnd_i), .cnt_i(cnt_i),
    .op_i(op_i), .wsel_i(wsel_i), .cf_i(cf_i), .res_o(res_o), .cf_o(cf_o));

  function automatic logic [32:0] model(logic [2:0] op, logic [1:0] ws,
                                        logic [31:0] v0, logic [4:0] n, logic c0);
    int w;
    logic [31:0] m, v;
    logic c, nc, sg;
    w  = (ws == 2'b00) ? 8 : (ws == 2'b01) ? 16 : 32;
    m  = (w == 32) ? 32'hFFFF_FFFF : ((32'd1 << w) - 32'd1);
    v  = v0 & m;
    c  = c0;
    sg = v[w-1];
    if (op != 3'd7) begin
      for (int i = 0; i < int'(n); i++) begin
        case (op)
          3'd0: begin c = v[w-1]; v = v << 1; end
          3'd1: begin c = v[0]; v = v >> 1; end
          3'd2: begin c = v[0]; v = (v >> 1) | (32'(sg) << (w-1)); end
          3'd3: begin c = v[w-1]; v = (v << 1) | 32'(c); end
          3'd4: begin c = v[0]; v = (v >> 1) | (32'(c) << (w-1)); end
          3'd5: begin nc = v[w-1]; v = (v << 1) | 32'(c); c = nc; end
          default: begin nc = v[0]; v = (v >> 1) | (32'(c) << (w-1)); c = nc; end
        endcase
        v = v & m;
      end
    end
    return {c, v};
  endfunction

  task automatic drive_exp(logic [2:0] op, logic [1:0] ws, logic [31:0] v,
                           logic [4:0] n, logic c, logic [31:0] er, logic ec, string tag);
    @(negedge clk);
    op_i = op; wsel_i = ws; opnd_i = v; cnt_i = n; cf_i = c;
    exp_res_q.push_back(er);
    exp_cf_q.push_back(ec);
    tag_q.push_back(tag);
  endtask

  task automatic drive(logic [2:0] op, logic [1:0] ws, logic [31:0] v,
                       logic [4:0] n, logic c, string tag);
    logic [32:0] e;
    e = model(op, ws, v, n, c);
    drive_exp(op, ws, v, n, c, e[31:0], e[32], tag);
  endtask

  always @(posedge clk) begin
    #1;
    if (rst_n && exp_res_q.size() > 0) begin
      logic [31:0] er;
      logic ec;
      string tg;
      er = exp_res_q.pop_front();
      ec = exp_cf_q.pop_front();
      tg = tag_q.pop_front();
      n_chk++;
      if (res_o !== er || cf_o !== ec) begin
        n_fail++;
        $display("FAIL %s res=%h exp=%h cf=%b exp=%b", tg, res_o, er, cf_o, ec);
      end
    end
  end

  function automatic string op_tag(logic [2:0] op, logic [4:0] n);
    if (n == 0) return "R2 zero count";
    case (op)
      3'd0, 3'd1: return "R3 logical shift";
      3'd2: return "R4 arithmetic shift";
      3'd3, 3'd4: return "R5 plain rotate";
      3'd5, 3'd6: return "R6 rotate through carry";
      default: return "R8 spare code";
    endcase
  endfunction

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    opnd_i = 32'hDEAD_BEEF; cnt_i = 5'd3; op_i = 3'd3; cf_i = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    n_chk++;
    if (res_o !== 32'd0 || cf_o !== 1'b0) begin
      n_fail++;
      $display("FAIL R1 reset res=%h exp=0 cf=%b exp=0", res_o, cf_o);
    end
    @(negedge clk);
    rst_n = 1'b1;
    // R5 / R6 known vectors on 16 bits
    drive_exp(3'd3, 2'b01, 32'h1234, 5'd1, 1'b0, 32'h2468, 1'b0, "R5 rol 1234 by 1");
    drive_exp(3'd4, 2'b01, 32'h1234, 5'd4, 1'b0, 32'h4123, 1'b0, "R5 ror 1234 by 4");
    drive_exp(3'd5, 2'b01, 32'h1234, 5'd4, 1'b0, 32'h2340, 1'b1, "R6 rcl 1234 by 4");
    // 8-bit chain
    drive_exp(3'd4, 2'b00, 32'h43, 5'd2, 1'b0, 32'hD0, 1'b1, "R5 chain ror");
    drive_exp(3'd3, 2'b00, 32'hD0, 5'd4, 1'b1, 32'h0D, 1'b1, "R5 chain rol");
    drive_exp(3'd6, 2'b00, 32'h0D, 5'd3, 1'b1, 32'h61, 1'b1, "R6 chain rcr");
    drive_exp(3'd5, 2'b00, 32'h61, 5'd4, 1'b1, 32'h1B, 1'b0, "R6 chain rcl");
    // R2 zero count on each code
    drive_exp(3'd0, 2'b01, 32'hABCD_8765, 5'd0, 1'b1, 32'h8765, 1'b1, "R2 shl count 0");
    drive_exp(3'd6, 2'b00, 32'h0000_01F0, 5'd0, 1'b0, 32'hF0, 1'b0, "R2 rcr count 0");
    // R3 boundaries
    drive_exp(3'd0, 2'b00, 32'h81, 5'd8, 1'b0, 32'h0, 1'b1, "R3 shl by width");
    drive_exp(3'd0, 2'b00, 32'h81, 5'd9, 1'b1, 32'h0, 1'b0, "R3 shl beyond width");
    drive_exp(3'd1, 2'b01, 32'h8001, 5'd16, 1'b0, 32'h0, 1'b1, "R3 shr by width");
    drive_exp(3'd1, 2'b00, 32'hF0, 5'd4, 1'b1, 32'h0F, 1'b0, "R3 shr zero fill");
    // R4 boundaries
    drive_exp(3'd2, 2'b00, 32'h80, 5'd20, 1'b0, 32'hFF, 1'b1, "R4 sar beyond width");
    drive_exp(3'd2, 2'b01, 32'h7FFE, 5'd31, 1'b1, 32'h0, 1'b0, "R4 sar positive");
    drive_exp(3'd2, 2'b00, 32'h96, 5'd2, 1'b0, 32'hE5, 1'b1, "R4 sar sign fill");
    // R5 reduced count zero
    drive_exp(3'd4, 2'b00, 32'h81, 5'd8, 1'b0, 32'h81, 1'b1, "R5 ror by width");
    drive_exp(3'd3, 2'b01, 32'h8000, 5'd16, 1'b1, 32'h8000, 1'b0, "R5 rol by width");
    // R6 reduced count zero
    drive_exp(3'd5, 2'b00, 32'h55, 5'd9, 1'b1, 32'h55, 1'b1, "R6 rcl by width+1");
    drive_exp(3'd6, 2'b01, 32'h0001, 5'd17, 1'b0, 32'h0001, 1'b0, "R6 rcr by width+1");
    // R7 width select and upper bits
    drive_exp(3'd3, 2'b00, 32'hFFFF_FF5A, 5'd4, 1'b0, 32'hA5, 1'b1, "R7 upper operand ignored");
    drive_exp(3'd3, 2'b11, 32'h8000_0001, 5'd1, 1'b0, 32'h0000_0003, 1'b1, "R7 code 11 is 32 bits");
    drive_exp(3'd1, 2'b10, 32'h8000_0000, 5'd31, 1'b0, 32'h1, 1'b0, "R7 code 10 is 32 bits");
    // R8 spare code
    drive_exp(3'd7, 2'b01, 32'hFF12_1234, 5'd3, 1'b1, 32'h1234, 1'b1, "R8 spare code");
    // mixed sweep checked against the step model
    for (int i = 0; i < 800; i++) begin
      logic [2:0] op;
      logic [4:0] n;
      op = 3'($urandom_range(0, 7));
      n  = 5'($urandom_range(0, 31));
      drive(op, 2'($urandom_range(0, 3)), $urandom, n, 1'($urandom_range(0, 1)), op_tag(op, n));
    end
    // R1 latency: output stays between edges
    @(negedge clk);
    op_i = 3'd7; cnt_i = 5'd0; opnd_i = 32'h0000_5555; wsel_i = 2'b10; cf_i = 1'b1;
    #1;
    n_chk++;
    if (res_o === 32'h0000_5555) begin
      n_fail++;
      $display("FAIL R1 latency res=%h exp=previous value", res_o);
    end
    exp_res_q.push_back(32'h0000_5555);
    exp_cf_q.push_back(1'b1);
    tag_q.push_back("R1 registered result");
    repeat (4) @(posedge clk);
    #2;
    finish_run();
  end
endmodule